// File: doc/BRIEF.md
# Condition Field Packer

This block turns a run of 4-bit condition fields into data for integer registers. A command names a vector length VL, a starting field index, a flag that says whether the field index advances per element (vector source) or stays fixed (scalar source), a mode, a 4-bit mask, a 4-bit invert pattern and a base integer register index. The block then reads one field per clock and works out a per-element result. In bit mode the result is one bit. In nibble mode the result is four bits. The results go into one or more 64-bit register writes.

Results are packed from the least significant end upward. Every destination bit that no element fills is written as zero. A vector source in bit mode packs eight elements per register and moves to the next register after every eighth element. A scalar source in bit mode packs all elements into one register. Nibble mode packs up to sixteen 4-bit results into one register. The condition fields are held in a small store inside the block, which is loaded through its own write port. The integer writes leave the block on a write port. A one-cycle done pulse marks the end of each command.

The register bit numbering is MSB-first, so bit 63 is the least significant bit. Element i in vector bit mode therefore lands at bit 63-(i mod 8), which is bit i mod 8 counted from the LSB.

Top module: `cond_field_packer`

## Requirements
- R1: After reset, `done`, `err` and `intWrEn` are low and `intWrData` is zero.
- R2: In bit mode with a vector source, element i goes to LSB-based bit (i mod 8) of register (baseReg + i/8) mod NUM_REGS. One write is issued after each eighth element and one after the last element. All other bits of each written word are zero.
- R3: In bit mode with a scalar source, element i goes to LSB-based bit i of register baseReg. A single write is issued after the last element, and bits at or above VL are zero.
- R4: In nibble mode, element i goes to LSB-based bits 4i to 4i+3 of register baseReg. A single write is issued after the last element, and the unused upper bits are zero.
- R5: Element i reads field (baseField + i) mod NUM_FIELDS for a vector source, or field baseField for a scalar source. NUM_FIELDS is a power of two. The nibble result is (field AND fmsk) XOR fmap, and the bit result is the OR of those four bits.
- R6: A start with VL above 16 in nibble mode, or with VL above 64 in any mode, makes no write. It raises `err` together with `done` for one cycle, in the cycle after the start edge.
- R7: Element i is processed on clock edge i+1 after the start edge. A write is visible in the cycle that follows that edge. `done` is high for exactly one cycle, in the cycle after edge VL+1, and it never coincides with a write.
- R8: A start with VL = 0 makes no write and raises `done` without `err` in the cycle after the start edge.
- R9: A start pulse while a command is running is ignored, and the running command's writes and timing are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfWrEn | input | 1 | Condition field store write enable |
| cfWrIdx | input | 6 | Condition field store write index |
| cfWrData | input | 4 | Condition field write value |
| start | input | 1 | Command strobe, sampled while idle |
| vl | input | 7 | Vector length, 0 to 127 (values above the limits are rejected) |
| baseField | input | 6 | First condition field index |
| isVec | input | 1 | 1: field index advances per element; 0: fixed field |
| nibbleMode | input | 1 | 1: 4-bit result per element; 0: 1-bit result |
| fmsk | input | 4 | Field mask |
| fmap | input | 4 | Field invert pattern |
| baseReg | input | 5 | First destination integer register |
| intWrEn | output | 1 | Integer register write strobe |
| intWrIdx | output | 5 | Integer register write index |
| intWrData | output | 64 | Integer register write value |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Command rejected, high together with done |

## Verification
The start edge is counted as edge 0. The write carrying element i must be visible after edge i+1. A rejected or empty command must show `done` after edge 1, and a normal command must show `done` after edge VL+1. The bench builds a per-cycle table of expected write strobe, index, data, done and err for each command from the packing rules. It then samples at each falling edge from cycle 0 to one cycle past the expected done pulse, so a write or pulse that arrives one cycle early or late is caught in the cycle where it differs.

// File: rtl/cfpk_pkg.sv
package cfpk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } cfpk_state_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture command operands
    logic step;   // process the current element
    logic flush;  // current element closes a destination word
  } cfpk_ctrl_t;

endpackage

// File: rtl/cfpk_field_file.sv
module cfpk_field_file #(
  parameter int NUM_FIELDS  = 64,
  parameter int FIELD_W     = 4,
  localparam int IDX_W      = $clog2(NUM_FIELDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [FIELD_W-1:0] wrData,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [FIELD_W-1:0] rdData
);

  logic [FIELD_W-1:0] fieldMem [NUM_FIELDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_FIELDS; k++) fieldMem[k] <= '0;
    end else if (wrEn) begin
      fieldMem[wrIdx] <= wrData;
    end
  end

  assign rdData = fieldMem[rdIdx];

endmodule

// File: rtl/cfpk_ctrl.sv
module cfpk_ctrl
  import cfpk_pkg::*;
#(
  parameter int MAX_VL   = 64,
  parameter int NIB_MAX  = 16,
  parameter int GROUP    = 8,
  localparam int VL_W    = $clog2(MAX_VL + 1),
  localparam int GRP_W   = $clog2(GROUP)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [VL_W-1:0] vl,
  input  logic            isVec,
  input  logic            nibbleMode,
  output cfpk_ctrl_t      ctrl,
  output logic [VL_W-1:0] elemIdx,
  output logic            done,
  output logic            err
);

  cfpk_state_t stateQ;
  logic [VL_W-1:0] vlQ;
  logic [VL_W-1:0] elemQ;
  logic            isVecQ;
  logic            nibbleQ;
  logic            errPendQ;

  logic badVl;
  logic lastElem;
  logic groupEnd;

  assign badVl = (vl > VL_W'(MAX_VL)) || (nibbleMode && (vl > VL_W'(NIB_MAX)));
  assign lastElem = (elemQ == vlQ - 1'b1);
  assign groupEnd = isVecQ && !nibbleQ && (elemQ[GRP_W-1:0] == {GRP_W{1'b1}});

  always_comb begin
    ctrl       = '0;
    ctrl.load  = (stateQ == ST_IDLE) && start;
    ctrl.step  = (stateQ == ST_RUN);
    ctrl.flush = (stateQ == ST_RUN) && (lastElem || groupEnd);
  end

  assign elemIdx = elemQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      vlQ      <= '0;
      elemQ    <= '0;
      isVecQ   <= 1'b0;
      nibbleQ  <= 1'b0;
      errPendQ <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            vlQ     <= vl;
            isVecQ  <= isVec;
            nibbleQ <= nibbleMode;
            elemQ   <= '0;
            if (badVl) begin
              errPendQ <= 1'b1;
              stateQ   <= ST_FIN;
            end else if (vl == '0) begin
              stateQ <= ST_FIN;
            end else begin
              stateQ <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          elemQ <= elemQ + 1'b1;
          if (lastElem) stateQ <= ST_FIN;
        end
        ST_FIN: begin
          done     <= 1'b1;
          err      <= errPendQ;
          errPendQ <= 1'b0;
          stateQ   <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfpk_datapath.sv
module cfpk_datapath
  import cfpk_pkg::*;
#(
  parameter int NUM_FIELDS  = 64,
  parameter int NUM_REGS    = 32,
  parameter int XLEN        = 64,
  parameter int FIELD_W     = 4,
  parameter int MAX_VL      = 64,
  parameter int GROUP       = 8,
  localparam int VL_W       = $clog2(MAX_VL + 1),
  localparam int FIDX_W     = $clog2(NUM_FIELDS),
  localparam int RIDX_W     = $clog2(NUM_REGS),
  localparam int POS_W      = $clog2(XLEN),
  localparam int GRP_W      = $clog2(GROUP),
  localparam int NIB_SHIFT  = $clog2(FIELD_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cfpk_ctrl_t         ctrl,
  input  logic [VL_W-1:0]    elemIdx,
  input  logic [FIDX_W-1:0]  baseField,
  input  logic               isVec,
  input  logic               nibbleMode,
  input  logic [FIELD_W-1:0] fmsk,
  input  logic [FIELD_W-1:0] fmap,
  input  logic [RIDX_W-1:0]  baseReg,
  output logic [FIDX_W-1:0]  fieldRdIdx,
  input  logic [FIELD_W-1:0] fieldRdData,
  output logic               intWrEn,
  output logic [RIDX_W-1:0]  intWrIdx,
  output logic [XLEN-1:0]    intWrData
);

  logic [FIDX_W-1:0]  baseFieldQ;
  logic               isVecQ;
  logic               nibbleQ;
  logic [FIELD_W-1:0] fmskQ;
  logic [FIELD_W-1:0] fmapQ;
  logic [RIDX_W-1:0]  baseRegQ;
  logic [XLEN-1:0]    accQ;

  logic [FIELD_W-1:0] nibVal;
  logic               bitVal;
  logic [XLEN-1:0]    valWide;
  logic [POS_W-1:0]   pos;
  logic [XLEN-1:0]    merged;
  logic [RIDX_W-1:0]  dstReg;

  // field selection: advance per element only for a vector source
  assign fieldRdIdx = isVecQ ? (baseFieldQ + FIDX_W'(elemIdx)) : baseFieldQ;

  assign nibVal  = (fieldRdData & fmskQ) ^ fmapQ;
  assign bitVal  = |nibVal;
  assign valWide = nibbleQ ? XLEN'(nibVal) : XLEN'(bitVal);

  always_comb begin
    if (nibbleQ)     pos = POS_W'(elemIdx) << NIB_SHIFT;
    else if (isVecQ) pos = POS_W'(elemIdx[GRP_W-1:0]);
    else             pos = POS_W'(elemIdx);
  end

  assign merged = accQ | (valWide << pos);

  always_comb begin
    if (isVecQ && !nibbleQ) dstReg = baseRegQ + RIDX_W'(elemIdx >> GRP_W);
    else                    dstReg = baseRegQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseFieldQ <= '0;
      isVecQ     <= 1'b0;
      nibbleQ    <= 1'b0;
      fmskQ      <= '0;
      fmapQ      <= '0;
      baseRegQ   <= '0;
      accQ       <= '0;
      intWrEn    <= 1'b0;
      intWrIdx   <= '0;
      intWrData  <= '0;
    end else begin
      intWrEn <= ctrl.step && ctrl.flush;
      if (ctrl.load) begin
        baseFieldQ <= baseField;
        isVecQ     <= isVec;
        nibbleQ    <= nibbleMode;
        fmskQ      <= fmsk;
        fmapQ      <= fmap;
        baseRegQ   <= baseReg;
        accQ       <= '0;
      end else if (ctrl.step) begin
        accQ <= ctrl.flush ? '0 : merged;
        if (ctrl.flush) begin
          intWrIdx  <= dstReg;
          intWrData <= merged;
        end
      end
    end
  end

endmodule

// File: rtl/cond_field_packer.sv
module cond_field_packer
  import cfpk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfWrEn,
  input  logic [5:0]  cfWrIdx,
  input  logic [3:0]  cfWrData,
  input  logic        start,
  input  logic [6:0]  vl,
  input  logic [5:0]  baseField,
  input  logic        isVec,
  input  logic        nibbleMode,
  input  logic [3:0]  fmsk,
  input  logic [3:0]  fmap,
  input  logic [4:0]  baseReg,
  output logic        intWrEn,
  output logic [4:0]  intWrIdx,
  output logic [63:0] intWrData,
  output logic        done,
  output logic        err
);

  localparam int NUM_FIELDS = 64;
  localparam int NUM_REGS   = 32;
  localparam int XLEN       = 64;
  localparam int FIELD_W    = 4;
  localparam int MAX_VL     = 64;
  localparam int GROUP      = 8;
  localparam int NIB_MAX    = XLEN / FIELD_W;
  localparam int VL_W       = $clog2(MAX_VL + 1);
  localparam int FIDX_W     = $clog2(NUM_FIELDS);

  cfpk_ctrl_t         ctrl;
  logic [VL_W-1:0]    elemIdx;
  logic [FIDX_W-1:0]  fieldRdIdx;
  logic [FIELD_W-1:0] fieldRdData;

  cfpk_field_file #(
    .NUM_FIELDS(NUM_FIELDS),
    .FIELD_W   (FIELD_W)
  ) fieldFile_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (cfWrEn),
    .wrIdx (cfWrIdx),
    .wrData(cfWrData),
    .rdIdx (fieldRdIdx),
    .rdData(fieldRdData)
  );

  cfpk_ctrl #(
    .MAX_VL (MAX_VL),
    .NIB_MAX(NIB_MAX),
    .GROUP  (GROUP)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .vl        (vl),
    .isVec     (isVec),
    .nibbleMode(nibbleMode),
    .ctrl      (ctrl),
    .elemIdx   (elemIdx),
    .done      (done),
    .err       (err)
  );

  cfpk_datapath #(
    .NUM_FIELDS(NUM_FIELDS),
    .NUM_REGS  (NUM_REGS),
    .XLEN      (XLEN),
    .FIELD_W   (FIELD_W),
    .MAX_VL    (MAX_VL),
    .GROUP     (GROUP)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .elemIdx    (elemIdx),
    .baseField  (baseField),
    .isVec      (isVec),
    .nibbleMode (nibbleMode),
    .fmsk       (fmsk),
    .fmap       (fmap),
    .baseReg    (baseReg),
    .fieldRdIdx (fieldRdIdx),
    .fieldRdData(fieldRdData),
    .intWrEn    (intWrEn),
    .intWrIdx   (intWrIdx),
    .intWrData  (intWrData)
  );

endmodule

// File: rtl/cond_field_packer_chk.sv
module cond_field_packer_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic intWrEn,
  input logic done,
  input logic err
);

  // R6: a rejection is reported together with the end pulse
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  // R6: a rejected command never writes
  a_r6_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    err |-> !intWrEn);

  // R7: the end pulse lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: the end pulse never shares a cycle with a write
  a_r7_done_no_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !intWrEn);

  // R7: no write directly follows the end pulse
  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !intWrEn);

  // R6: err pulse lasts one cycle
  a_r6_err_single: assert property (@(posedge clk) disable iff (!rstN)
    err |=> !err);

  // R8: a command with nothing to do starts with no write on the next edge
  a_r8_no_write_after_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    (start && done) |=> !intWrEn);

endmodule

bind cond_field_packer cond_field_packer_chk chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .intWrEn(intWrEn),
  .done   (done),
  .err    (err)
);

// File: tb/cond_field_packer_tb_top.sv
`timescale 1ns/1ps
module cond_field_packer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfWrEn = 1'b0;
  logic [5:0]  cfWrIdx = '0;
  logic [3:0]  cfWrData = '0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic [5:0]  baseField = '0;
  logic        isVec = 1'b0;
  logic        nibbleMode = 1'b0;
  logic [3:0]  fmsk = '0;
  logic [3:0]  fmap = '0;
  logic [4:0]  baseReg = '0;
  logic        intWrEn;
  logic [4:0]  intWrIdx;
  logic [63:0] intWrData;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [3:0]  cfModel [64];
  logic        expEn   [0:80];
  logic [4:0]  expIdx  [0:80];
  logic [63:0] expData [0:80];
  logic        expDone [0:80];
  logic        expErr  [0:80];

  always #2 clk = ~clk;

  cond_field_packer dut_i (
    .clk(clk), .rstN(rstN), .cfWrEn(cfWrEn), .cfWrIdx(cfWrIdx), .cfWrData(cfWrData),
    .start(start), .vl(vl), .baseField(baseField), .isVec(isVec),
    .nibbleMode(nibbleMode), .fmsk(fmsk), .fmap(fmap), .baseReg(baseReg),
    .intWrEn(intWrEn), .intWrIdx(intWrIdx), .intWrData(intWrData),
    .done(done), .err(err)
  );

  task automatic fail(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic writeField(input int idx, input logic [3:0] val);
    @(negedge clk);
    cfWrEn = 1'b1; cfWrIdx = 6'(idx); cfWrData = val;
    cfModel[idx] = val;
    @(negedge clk);
    cfWrEn = 1'b0;
  endtask

  // Runs one command and compares every cycle against a model table.
  task automatic runCmd(input int n, input int bField, input bit vec, input bit nib,
                        input logic [3:0] msk, input logic [3:0] inv, input int bReg,
                        input string reqW, input string reqD, input bit poke);
    bit bad;
    int doneCyc;
    logic [63:0] acc;
    bad = (n > 64) || (nib && n > 16);
    for (int c = 0; c <= 80; c++) begin
      expEn[c] = 0; expIdx[c] = '0; expData[c] = '0; expDone[c] = 0; expErr[c] = 0;
    end
    acc = '0;
    if (bad || n == 0) begin
      doneCyc = 1;
      expErr[1] = bad;
    end else begin
      for (int i = 0; i < n; i++) begin
        logic [3:0] f, v4;
        int p;
        f  = vec ? cfModel[(bField + i) % 64] : cfModel[bField];
        v4 = (f & msk) ^ inv;
        p  = nib ? 4 * i : (vec ? i % 8 : i);
        acc = acc | ((nib ? {60'b0, v4} : {63'b0, |v4}) << p);
        if (i == n - 1 || (!nib && vec && i % 8 == 7)) begin
          expEn[i+1]   = 1;
          expIdx[i+1]  = 5'((bReg + ((!nib && vec) ? i / 8 : 0)) % 32);
          expData[i+1] = acc;
          acc = '0;
        end
      end
      doneCyc = n + 1;
    end
    expDone[doneCyc] = 1;

    @(negedge clk);
    start = 1'b1; vl = 7'(n); baseField = 6'(bField); isVec = vec; nibbleMode = nib;
    fmsk = msk; fmap = inv; baseReg = 5'(bReg);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= doneCyc + 1; c++) begin
      if (c > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (poke && c == 2) begin
        start = 1'b1; vl = 7'd3; nibbleMode = 1'b1; isVec = 1'b0; baseReg = 5'd9;
      end else if (poke && c == 3) begin
        start = 1'b0;
      end
      checks++;
      if (intWrEn !== expEn[c] ||
          (expEn[c] && (intWrIdx !== expIdx[c] || intWrData !== expData[c]))) begin
        fail(reqW, $sformatf("write cycle %0d en/idx", c),
             {58'b0, intWrEn, intWrIdx}, {58'b0, expEn[c], expIdx[c]});
        if (expEn[c]) fail(reqW, $sformatf("write cycle %0d data", c), intWrData, expData[c]);
      end
      checks++;
      if (done !== expDone[c] || err !== expErr[c])
        fail(reqD, $sformatf("done/err cycle %0d", c),
             {62'b0, done, err}, {62'b0, expDone[c], expErr[c]});
    end
  endtask

  initial begin
    for (int k = 0; k < 64; k++) cfModel[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (done !== 1'b0 || err !== 1'b0 || intWrEn !== 1'b0 || intWrData !== '0)
      fail("R1", "reset outputs", {61'b0, done, err, intWrEn}, 64'd0);

    for (int k = 0; k < 64; k++) writeField(k, 4'((k * 7 + 3) & 15));

    runCmd(20, 5,  1, 0, 4'hF, 4'h0, 2,  "R2 R5", "R7", 0);
    runCmd(64, 60, 1, 0, 4'h5, 4'h2, 30, "R2 R5", "R7", 0);
    runCmd(13, 9,  0, 0, 4'hF, 4'h0, 4,  "R3 R5", "R7", 0);
    runCmd(64, 0,  0, 0, 4'h0, 4'h1, 7,  "R3", "R7", 0);
    runCmd(16, 3,  1, 1, 4'hF, 4'h0, 11, "R4 R5", "R7", 0);
    runCmd(7,  21, 0, 1, 4'hC, 4'h9, 12, "R4 R5", "R7", 0);
    runCmd(9,  62, 1, 1, 4'h6, 4'hA, 31, "R4 R5", "R7", 0);
    runCmd(17, 0,  1, 1, 4'hF, 4'h0, 1,  "R6", "R6", 0);
    runCmd(65, 0,  1, 0, 4'hF, 4'h0, 1,  "R6", "R6", 0);
    runCmd(0,  4,  1, 0, 4'hF, 4'h0, 1,  "R8", "R8", 0);
    runCmd(10, 33, 1, 0, 4'h3, 4'h1, 15, "R9", "R9", 1);
    runCmd(1,  40, 1, 0, 4'h8, 4'h0, 20, "R2", "R7", 0);
    writeField(8, 4'h0);
    runCmd(8,  8,  1, 0, 4'hF, 4'h0, 0,  "R2 R5", "R7", 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule